// File: doc/BRIEF.md
# Hardware Mutex Request/Grant Unit

This block is a hardware lock that up to sixteen software agents share through two 32-bit registers on a plain read/write strobe bus. Each agent has one bit in each register. An agent asks for the lock by writing a 1 to its bit of the request register. When the lock is free, the block hands it to one waiting agent and sets that agent's bit in the grant register. The grant register is therefore either zero or names the single owner.

The grant register is also the agent's control point for giving the lock back. Writing a 1 to the owner's grant bit frees the lock. Writing a 1 to any other grant bit withdraws that agent's waiting request. Waiting agents are served in rotating order, starting with the agent after the most recent owner, so no agent waits forever while others keep asking. Both registers are cleared by an asynchronous power-on reset and by a synchronous soft clear input.

Top module: `hw_lock_unit`

## Requirements
- R1: The request register is decoded at byte address 0x365C and the grant register at 0x3660. A read with `bus_rd` high returns the selected register, zero-extended in bits 31:16.
- R2: Each 1 in bits 15:0 of a request-register write sets that agent's request bit. Bits written as 0 and bits 31:16 leave the register unchanged. A set bit stays 1 while the request waits.
- R3: The grant register has at most one bit set. That bit holds its value until a release or a soft clear.
- R4: If the grant register is zero and any request bit is set at a clock edge, that edge sets exactly one grant bit and clears the same agent's request bit.
- R5: Among waiting requests, the grant goes to the first agent found by counting upward from the previous owner's index and wrapping. After reset the search starts at agent 0.
- R6: Writing a 1 to the owner's grant bit clears the grant register. The register then reads 0x0000 for at least one cycle before any new grant.
- R7: Writing a 1 to a grant bit that is not the owner's clears that agent's request bit, and it will not be granted. The owner is unaffected.
- R8: Grant-register bits written as 0, and bits 31:16, have no effect.
- R9: A request-register write that sets the current owner's bit is ignored.
- R10: After power-on reset (`por_n` low), both registers read zero. A cycle with `soft_clr` high also clears both.
- R11: Reads from any other address return zero, and writes to any other address change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_clr | input | 1 | Synchronous register clear, active high |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from the address |

## Verification
The bench looks at the cycle right after a release. A design that passes the lock straight to the next waiter would show a nonzero grant there instead of the required idle cycle. It checks that the rotating search wraps from agent 14 back to agent 2, which a fixed-priority or non-wrapping pointer would get wrong. It checks that a cancel clears only the target's request and leaves the owner untouched; a design that decodes the cancel loosely would instead drop the owner or keep the withdrawn request. It also checks that the owner re-requesting, zero writes, upper data bits, and writes to an unmapped address all leave both registers exactly as they were.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
   localparam int REG_W = 32;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_REQ  = 2'd1,
      SEL_GNT  = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/hwl_req_bank.sv
module hwl_req_bank #(
   parameter int N_AGENTS = 16
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                soft_clr,
   input  logic                set_en,
   input  logic [N_AGENTS-1:0] set_vec,
   input  logic [N_AGENTS-1:0] owner_vec,
   input  logic [N_AGENTS-1:0] cancel_vec,
   input  logic [N_AGENTS-1:0] win_vec,
   output logic [N_AGENTS-1:0] req_q
);
   logic [N_AGENTS-1:0] add_vec;
   logic [N_AGENTS-1:0] req_d;

   // owner cannot queue another request for the lock it holds
   assign add_vec = set_en ? (set_vec & ~owner_vec) : '0;
   assign req_d   = (req_q | add_vec) & ~cancel_vec & ~win_vec;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        req_q <= '0;
      else if (soft_clr) req_q <= '0;
      else               req_q <= req_d;
   end

   assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!por_n)
      (set_en && !soft_clr && ((set_vec & ~owner_vec & ~cancel_vec & ~win_vec) != '0))
      |=> ((req_q & $past(set_vec & ~owner_vec & ~cancel_vec & ~win_vec))
           == $past(set_vec & ~owner_vec & ~cancel_vec & ~win_vec)));

   assert_soft_clear_req_R10: assert property (@(posedge clk) disable iff (!por_n)
      soft_clr |=> (req_q == '0));
endmodule

// File: rtl/hwl_rr_arb.sv
module hwl_rr_arb #(
   parameter int N_AGENTS  = 16,
   parameter bit RR_ENABLE = 1'b1,
   localparam int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic [N_AGENTS-1:0] pend,
   input  logic [IDX_W-1:0]    last_idx,
   output logic [N_AGENTS-1:0] pick
);
   generate
      if (RR_ENABLE) begin : g_rotate
         always_comb begin
            logic found;
            pick  = '0;
            found = 1'b0;
            for (int i = 1; i <= N_AGENTS; i++) begin
               int idx;
               idx = (int'(last_idx) + i) % N_AGENTS;
               if (!found && pend[idx]) begin
                  pick[idx] = 1'b1;
                  found     = 1'b1;
               end
            end
         end
      end else begin : g_fixed
         always_comb begin
            logic found;
            pick  = '0;
            found = 1'b0;
            for (int i = 0; i < N_AGENTS; i++) begin
               if (!found && pend[i]) begin
                  pick[i] = 1'b1;
                  found   = 1'b1;
               end
            end
         end
         logic [IDX_W-1:0] unused_last;
         assign unused_last = last_idx;
      end
   endgenerate
endmodule

// File: rtl/hwl_grant_trk.sv
module hwl_grant_trk #(
   parameter int N_AGENTS = 16,
   localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                soft_clr,
   input  logic                wr_gnt,
   input  logic [N_AGENTS-1:0] wr_mask,
   input  logic [N_AGENTS-1:0] pick,
   output logic [N_AGENTS-1:0] gnt_q,
   output logic [IDX_W-1:0]    last_q,
   output logic [N_AGENTS-1:0] win_vec,
   output logic [N_AGENTS-1:0] cancel_vec
);
   logic             lock_free;
   logic             release_hit;
   logic             fire;
   logic [IDX_W-1:0] pick_idx;

   assign lock_free   = (gnt_q == '0);
   assign release_hit = wr_gnt && ((wr_mask & gnt_q) != '0);
   assign fire        = lock_free && (pick != '0);
   assign win_vec     = fire ? pick : '0;
   assign cancel_vec  = wr_gnt ? (wr_mask & ~gnt_q) : '0;

   always_comb begin
      pick_idx = '0;
      for (int i = 0; i < N_AGENTS; i++) begin
         if (pick[i]) pick_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         gnt_q  <= '0;
         last_q <= IDX_W'(N_AGENTS - 1);
      end else if (soft_clr) begin
         gnt_q  <= '0;
         last_q <= IDX_W'(N_AGENTS - 1);
      end else if (fire) begin
         gnt_q  <= pick;
         last_q <= pick_idx;
      end else if (release_hit) begin
         gnt_q  <= '0;
      end
   end

   assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0(gnt_q));

   assert_grant_holds_R3: assert property (@(posedge clk) disable iff (!por_n)
      (!lock_free && !release_hit && !soft_clr) |=> $stable(gnt_q));

   assert_release_gap_R6: assert property (@(posedge clk) disable iff (!por_n)
      release_hit |=> (gnt_q == '0));

   assert_free_grants_R4: assert property (@(posedge clk) disable iff (!por_n)
      (lock_free && (pick != '0) && !soft_clr) |=> (gnt_q == $past(pick)));

   assert_soft_clear_gnt_R10: assert property (@(posedge clk) disable iff (!por_n)
      soft_clr |=> (gnt_q == '0));
endmodule

// File: rtl/hw_lock_unit.sv
module hw_lock_unit
   import hwl_pkg::*;
#(
   parameter int          N_AGENTS   = 16,
   parameter int          ADDR_W     = 16,
   parameter logic [15:0] REQ_OFFSET = 16'h365C,
   parameter logic [15:0] GNT_OFFSET = 16'h3660,
   parameter bit          RR_ENABLE  = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              soft_clr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata
);
   localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

   initial begin
      if (N_AGENTS < 1 || N_AGENTS > 16)
         $error("hw_lock_unit: N_AGENTS must be 1..16");
      if (REQ_OFFSET == GNT_OFFSET)
         $error("hw_lock_unit: register offsets must differ");
      if (REQ_OFFSET[1:0] != 2'b00 || GNT_OFFSET[1:0] != 2'b00)
         $error("hw_lock_unit: offsets must be word aligned");
      if (ADDR_W < 16)
         $error("hw_lock_unit: ADDR_W too narrow for offsets");
   end

   reg_sel_e            sel;
   logic                wr_req;
   logic                wr_gnt;
   logic [N_AGENTS-1:0] wbits;
   logic [N_AGENTS-1:0] req_q;
   logic [N_AGENTS-1:0] gnt_q;
   logic [N_AGENTS-1:0] pend;
   logic [N_AGENTS-1:0] pick;
   logic [N_AGENTS-1:0] win_vec;
   logic [N_AGENTS-1:0] cancel_vec;
   logic [IDX_W-1:0]    last_q;

   always_comb begin
      if (bus_addr == ADDR_W'(REQ_OFFSET))      sel = SEL_REQ;
      else if (bus_addr == ADDR_W'(GNT_OFFSET)) sel = SEL_GNT;
      else                                      sel = SEL_NONE;
   end

   assign wr_req = bus_wr && (sel == SEL_REQ);
   assign wr_gnt = bus_wr && (sel == SEL_GNT);
   assign wbits  = bus_wdata[N_AGENTS-1:0];

   generate
      if (N_AGENTS < 32) begin : g_hi_unused
         logic [31-N_AGENTS:0] unused_wdata_hi;
         assign unused_wdata_hi = bus_wdata[31:N_AGENTS];
      end
   endgenerate

   // a request being withdrawn this cycle is not eligible for a grant
   assign pend = req_q & ~cancel_vec;

   hwl_req_bank #(.N_AGENTS(N_AGENTS)) req_bank_i (
      .clk        (clk),
      .por_n      (por_n),
      .soft_clr   (soft_clr),
      .set_en     (wr_req),
      .set_vec    (wbits),
      .owner_vec  (gnt_q),
      .cancel_vec (cancel_vec),
      .win_vec    (win_vec),
      .req_q      (req_q)
   );

   hwl_rr_arb #(.N_AGENTS(N_AGENTS), .RR_ENABLE(RR_ENABLE)) arb_i (
      .pend     (pend),
      .last_idx (last_q),
      .pick     (pick)
   );

   hwl_grant_trk #(.N_AGENTS(N_AGENTS)) grant_i (
      .clk        (clk),
      .por_n      (por_n),
      .soft_clr   (soft_clr),
      .wr_gnt     (wr_gnt),
      .wr_mask    (wbits),
      .pick       (pick),
      .gnt_q      (gnt_q),
      .last_q     (last_q),
      .win_vec    (win_vec),
      .cancel_vec (cancel_vec)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (sel)
            SEL_REQ: bus_rdata = REG_W'(req_q);
            SEL_GNT: bus_rdata = REG_W'(gnt_q);
            default: bus_rdata = '0;
         endcase
      end
   end

   assert_owner_never_pending_R9: assert property (@(posedge clk) disable iff (!por_n)
      ((req_q & gnt_q) == '0));

   assert_pick_from_pending_R5: assert property (@(posedge clk) disable iff (!por_n)
      ((pick & ~pend) == '0) && $onehot0(pick));

   assert_cancel_clears_R7: assert property (@(posedge clk) disable iff (!por_n)
      (cancel_vec != '0 && !soft_clr) |=> ((req_q & $past(cancel_vec)) == '0));

   assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!por_n)
      (sel == SEL_NONE && gnt_q != '0 && !soft_clr) |=> $stable(gnt_q));
endmodule

// File: tb/hw_lock_unit_tb_top.sv
module hw_lock_unit_tb_top;
   localparam logic [1:0]  OP_W  = 2'd0;
   localparam logic [1:0]  OP_R  = 2'd1;
   localparam logic [1:0]  OP_I  = 2'd2;
   localparam logic [15:0] A_RQ  = 16'h365C;
   localparam logic [15:0] A_GT  = 16'h3660;
   localparam logic [15:0] A_NX  = 16'h3664;

   typedef struct packed {
      logic [1:0]  op;
      logic [15:0] addr;
      logic [31:0] data;
      logic [31:0] expv;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 35;
   localparam vec_t VECS [NV] = '{
      '{OP_W, A_RQ, 32'h0000_0008, 32'h0, 8'd2},        // R2 agent 3 asks
      '{OP_R, A_RQ, 32'h0, 32'h0000_0008, 8'd2},        // R2 pending visible
      '{OP_R, A_GT, 32'h0, 32'h0000_0008, 8'd4},        // R4 granted
      '{OP_R, A_RQ, 32'h0, 32'h0000_0000, 8'd4},        // R4 winner cleared
      '{OP_W, A_RQ, 32'hFFFF_0021, 32'h0, 8'd2},        // R2 agents 0,5 + upper bits
      '{OP_R, A_RQ, 32'h0, 32'h0000_0021, 8'd2},
      '{OP_W, A_RQ, 32'h0000_0000, 32'h0, 8'd2},        // R2 zero write
      '{OP_R, A_RQ, 32'h0, 32'h0000_0021, 8'd2},
      '{OP_W, A_RQ, 32'h0000_0008, 32'h0, 8'd9},        // R9 owner re-asks
      '{OP_R, A_RQ, 32'h0, 32'h0000_0021, 8'd9},
      '{OP_W, A_GT, 32'h0000_0000, 32'h0, 8'd8},        // R8 zero write
      '{OP_R, A_GT, 32'h0, 32'h0000_0008, 8'd8},
      '{OP_W, A_GT, 32'h0000_0008, 32'h0, 8'd6},        // R6 release
      '{OP_R, A_GT, 32'h0, 32'h0000_0000, 8'd6},        // R6 idle cycle
      '{OP_R, A_GT, 32'h0, 32'h0000_0020, 8'd5},        // R5 after 3 comes 5
      '{OP_R, A_RQ, 32'h0, 32'h0000_0001, 8'd4},
      '{OP_W, A_GT, 32'h0000_0001, 32'h0, 8'd7},        // R7 cancel agent 0
      '{OP_R, A_RQ, 32'h0, 32'h0000_0000, 8'd7},
      '{OP_R, A_GT, 32'h0, 32'h0000_0020, 8'd7},        // R7 owner unaffected
      '{OP_W, A_GT, 32'h0000_0020, 32'h0, 8'd6},        // R6 release
      '{OP_I, A_RQ, 32'h0, 32'h0, 8'd6},
      '{OP_R, A_GT, 32'h0, 32'h0000_0000, 8'd6},
      '{OP_W, A_RQ, 32'h0000_4004, 32'h0, 8'd5},        // R5 agents 2,14
      '{OP_R, A_RQ, 32'h0, 32'h0000_4004, 8'd5},
      '{OP_R, A_GT, 32'h0, 32'h0000_4000, 8'd5},        // R5 14 first
      '{OP_W, A_GT, 32'h0000_4000, 32'h0, 8'd6},
      '{OP_R, A_GT, 32'h0, 32'h0000_0000, 8'd6},
      '{OP_R, A_GT, 32'h0, 32'h0000_0004, 8'd5},        // R5 wraps to 2
      '{OP_R, A_RQ, 32'h0, 32'h0000_0000, 8'd4},
      '{OP_R, A_NX, 32'h0, 32'h0000_0000, 8'd11},       // R11 unmapped read
      '{OP_W, A_NX, 32'h0000_FFFF, 32'h0, 8'd11},       // R11 unmapped write
      '{OP_R, A_RQ, 32'h0, 32'h0000_0000, 8'd11},
      '{OP_R, A_GT, 32'h0, 32'h0000_0004, 8'd11},
      '{OP_W, A_GT, 32'hFFFF_0000, 32'h0, 8'd8},        // R8 upper bits only
      '{OP_R, A_GT, 32'h0, 32'h0000_0004, 8'd1}         // R1 readback zero-extended
   };

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        soft_clr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   int          n_checks = 0;
   int          n_errors = 0;
   int          cycles = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   hw_lock_unit dut_i (
      .clk       (clk),
      .por_n     (por_n),
      .soft_clr  (soft_clr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input int rq, input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_errors++;
         $display("FAIL R%0d actual=%08h expected=%08h", rq, act, expv);
      end
   endtask

   task automatic do_read(input logic [15:0] a, input logic [31:0] expv, input int rq);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
      #2;
      check(rq, bus_rdata, expv);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   initial begin
      wait (cycles > 20000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      // R10 power-on state
      do_read(A_RQ, 32'h0, 10);
      do_read(A_GT, 32'h0, 10);
      // R1 readback of each register address
      do_read(A_RQ, 32'h0, 1);

      for (int k = 0; k < NV; k++) begin
         case (VECS[k].op)
            OP_W: do_write(VECS[k].addr, VECS[k].data);
            OP_R: do_read(VECS[k].addr, VECS[k].expv, int'(VECS[k].rq));
            default: begin
               @(negedge clk);
               bus_wr = 1'b0; bus_rd = 1'b0;
            end
         endcase
      end

      // R10 soft clear with a held lock and pending requests
      do_write(A_RQ, 32'h0000_0003);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; soft_clr = 1'b1;
      @(negedge clk);
      soft_clr = 1'b0; bus_rd = 1'b1; bus_addr = A_RQ;
      #2;
      check(10, bus_rdata, 32'h0);
      do_read(A_GT, 32'h0, 10);
      do_read(A_GT, 32'h0, 10);

      // R5 pointer restarts at agent 0 after soft clear
      do_write(A_RQ, 32'h0000_8001);
      do_read(A_RQ, 32'h0000_8001, 5);
      do_read(A_GT, 32'h0000_0001, 5);

      // R7 cancel of the only waiter while owner holds
      do_write(A_GT, 32'h0000_8000);
      do_read(A_RQ, 32'h0, 7);
      do_read(A_GT, 32'h0000_0001, 7);

      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule